// File: doc/BRIEF.md
# Serial Status and Transmit Buffer

This block holds the 8-bit status register and the transmit path of a byte-oriented asynchronous serial port. Software reaches it through a small register port: one select line picks either the status register or the transmit data holding register, with separate read and write strobes and a combinational read-data bus. A byte written to the holding register is moved into a shift register when the transmitter is enabled and idle. It is then sent as one start bit (0), eight data bits least significant first, and one stop bit (1). Each bit lasts until the next pulse of an external bit-tick input.

The receive side lives elsewhere and reports only through single-cycle pulses. These pulses signal a byte received, an overrun, a framing error, a parity error, and the value of the received multiprocessor bit. Each pulse raises its flag in the status register. The five sticky flags can be lowered by software only through a two-step protocol: first a status read that sees the flag as 1, then a write of 0 to that flag.

Top module: `serial_status_xmit`

## Requirements
- R1: After reset, and on the cycle after `standby_i` is high, the status register reads 0x84 (bits 7 and 2 set, all others clear). Standby also empties the transmitter.
- R2: Status bit positions: 7 transmit-buffer-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-done, 1 received MP bit, 0 transmit MP bit. A pulse on `rx_ready_i`, `rx_overrun_i`, `rx_frame_err_i` or `rx_parity_err_i` sets bit 6, 5, 4 or 3 respectively.
- R3: A status write (`reg_sel_i`=0) never sets bits 7..3 when the bit written is 1, and never changes bits 2 and 1.
- R4: A status write of 0 clears one of bits 7..3 only when a status read strobe (`reg_rd_i`, `reg_sel_i`=0) has returned that bit as 1 since the bit last became 1 and since the last write-0 attempt on it. Otherwise the write leaves the bit unchanged.
- R5: When a hardware set event and a software clear of the same flag fall in one cycle, the flag stays 1.
- R6: Status bit 0 takes the value of `reg_wdata_i[0]` on every status write and is read back unchanged.
- R7: Bit 1 loads `rx_mpb_i` on a cycle with `rx_ready_i` high and otherwise holds.
- R8: A write with `reg_sel_i`=1 loads the holding register, which reads back with `reg_sel_i`=1, and clears bit 7 unless bit 7 is being forced high in that cycle.
- R9: Bit 7 is forced to 1 while `tx_enable_i` is 0, and no transfer happens then. A transfer from the holding register to the shifter sets bit 7 in the cycle after the holding register was written (transmitter idle and enabled).
- R10: `txd_o` idles at 1. A frame is start bit 0, data bits LSB first, stop bit 1; each bit is replaced by the next on a `bit_tick_i` pulse.
- R11: Bit 2 clears when a transfer starts. It sets when the stop bit's tick arrives with bit 7 set; if a byte is pending instead, the next transfer starts one cycle later and bit 2 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Synchronous return to the reset state |
| tx_enable_i | input | 1 | Transmitter enable |
| bit_tick_i | input | 1 | One-cycle strobe ending each serial bit |
| reg_sel_i | input | 1 | 0 = status register, 1 = transmit holding register |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| rx_ready_i | input | 1 | Received-byte pulse |
| rx_mpb_i | input | 1 | Received MP bit, valid with rx_ready_i |
| rx_overrun_i | input | 1 | Overrun pulse |
| rx_frame_err_i | input | 1 | Framing error pulse |
| rx_parity_err_i | input | 1 | Parity error pulse |
| txd_o | output | 1 | Serial output |

## Verification
The two functions that can meet in one cycle are a software clear of a sticky flag and the hardware event that sets it. The bench arms the receive-full flag with a status read. In one cycle it then drives a write of 0 to that flag together with an `rx_ready_i` pulse, and expects the flag to read 1 afterwards. A second case sets a holding-register write against the forced empty flag of a disabled transmitter and expects the flag to stay 1 with the line idle.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int STAT_W = 8;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h84;

    // status bit positions (software-visible contract)
    localparam int IDX_TXE  = 7;
    localparam int IDX_RXF  = 6;
    localparam int IDX_OVR  = 5;
    localparam int IDX_FRM  = 4;
    localparam int IDX_PAR  = 3;
    localparam int IDX_TEND = 2;
    localparam int IDX_RMPB = 1;
    localparam int IDX_TMPB = 0;

    // sticky flags occupy bits IDX_TXE down to IDX_PAR
    localparam int STICKY_N = IDX_TXE - IDX_PAR + 1;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_TXDATA = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/sst_flags.sv
module sst_flags
    import sst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              tx_enable_i,
    input  logic              stat_rd_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic              txdata_wr_i,
    input  logic              xfer_i,
    input  logic              tx_done_i,
    input  logic              rx_ready_i,
    input  logic              rx_mpb_i,
    input  logic              rx_overrun_i,
    input  logic              rx_frame_err_i,
    input  logic              rx_parity_err_i,
    output logic [STAT_W-1:0] status_o
);
    typedef struct packed {
        logic [STAT_W-1:0]   stat;
        logic [STICKY_N-1:0] armed;
    } flags_t;

    flags_t q, d;

    logic [STICKY_N-1:0] sticky_q, sticky_d, hw_set, hw_clr, sw_clr;

    always_comb begin
        d        = q;
        sticky_q = q.stat[IDX_TXE:IDX_PAR];
        hw_set   = {xfer_i | ~tx_enable_i, rx_ready_i, rx_overrun_i,
                    rx_frame_err_i, rx_parity_err_i};
        hw_clr   = {txdata_wr_i, {(STICKY_N-1){1'b0}}};
        sw_clr   = stat_wr_i ? (~wdata_i[IDX_TXE:IDX_PAR] & q.armed) : '0;
        // set events win over any clear in the same cycle
        sticky_d = (sticky_q & ~(hw_clr | sw_clr)) | hw_set;
        d.stat[IDX_TXE:IDX_PAR] = sticky_d;
        // arm on a read that sees 1; disarm on a clear attempt or when low
        d.armed  = ((q.armed & ~sw_clr) | (stat_rd_i ? sticky_q : '0)) & sticky_d;

        if (xfer_i)
            d.stat[IDX_TEND] = 1'b0;
        else if (tx_done_i && q.stat[IDX_TXE])
            d.stat[IDX_TEND] = 1'b1;

        if (rx_ready_i)
            d.stat[IDX_RMPB] = rx_mpb_i;
        if (stat_wr_i)
            d.stat[IDX_TMPB] = wdata_i[IDX_TMPB];

        if (standby_i) begin
            d.stat  = STAT_RESET;
            d.armed = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.stat  <= STAT_RESET;
            q.armed <= '0;
        end else begin
            q <= d;
        end
    end

    assign status_o = q.stat;

    // R1
    standby_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (status_o == STAT_RESET));
    // R3
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[IDX_RXF] && !rx_ready_i && !standby_i) |=> !status_o[IDX_RXF]);
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun_i && !standby_i) |=> status_o[IDX_OVR]);
    // R7
    rmpb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready_i && !standby_i) |=> $stable(status_o[IDX_RMPB]));
    // R9
    txe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable_i |=> status_o[IDX_TXE]);
endmodule

// File: rtl/sst_tx.sv
module sst_tx #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 standby_i,
    input  logic                 tx_enable_i,
    input  logic                 bit_tick_i,
    input  logic                 txdata_wr_i,
    input  logic [DATA_BITS-1:0] wdata_i,
    input  logic                 txe_i,
    output logic                 xfer_o,
    output logic                 done_o,
    output logic                 busy_o,
    output logic                 txd_o,
    output logic [DATA_BITS-1:0] tdr_o
);
    localparam int FRAME_W = DATA_BITS + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [DATA_BITS-1:0] tdr;
        logic [FRAME_W-1:0]   shift;
        logic [CNT_W-1:0]     cnt;
        logic                 busy;
    } tx_t;

    tx_t q, d;
    logic xfer, done;

    always_comb begin
        d    = q;
        // a holding-register write in this cycle defers the transfer one cycle
        xfer = tx_enable_i & ~txe_i & ~q.busy & ~txdata_wr_i & ~standby_i;
        done = q.busy & bit_tick_i & (q.cnt == LAST) & ~standby_i;

        if (txdata_wr_i)
            d.tdr = wdata_i;

        if (xfer) begin
            d.shift = {1'b1, q.tdr, 1'b0};
            d.cnt   = '0;
            d.busy  = 1'b1;
        end else if (q.busy && bit_tick_i) begin
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
            end else begin
                d.shift = {1'b1, q.shift[FRAME_W-1:1]};
                d.cnt   = q.cnt + 1'b1;
            end
        end

        if (standby_i)
            d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign xfer_o = xfer;
    assign done_o = done;
    assign busy_o = q.busy;
    assign txd_o  = q.busy ? q.shift[0] : 1'b1;
    assign tdr_o  = q.tdr;

    // R10
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> (txd_o == 1'b0));
    // R10
    stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (txd_o == 1'b1));
    // R11
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !txe_i && tx_enable_i && !txdata_wr_i) |=> xfer_o);
endmodule

// File: rtl/serial_status_xmit.sv
module serial_status_xmit
    import sst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby_i,
    input  logic       tx_enable_i,
    input  logic       bit_tick_i,
    input  logic       reg_sel_i,
    input  logic       reg_rd_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       rx_ready_i,
    input  logic       rx_mpb_i,
    input  logic       rx_overrun_i,
    input  logic       rx_frame_err_i,
    input  logic       rx_parity_err_i,
    output logic       txd_o
);
    reg_sel_e          sel;
    logic              stat_rd, stat_wr, data_wr;
    logic              xfer, tx_done, tx_busy;
    logic [STAT_W-1:0] status;
    logic [7:0]        tdr;

    assign sel     = reg_sel_e'(reg_sel_i);
    assign stat_rd = reg_rd_i && (sel == SEL_STATUS);
    assign stat_wr = reg_wr_i && (sel == SEL_STATUS);
    assign data_wr = reg_wr_i && (sel == SEL_TXDATA);

    sst_flags u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .standby_i      (standby_i),
        .tx_enable_i    (tx_enable_i),
        .stat_rd_i      (stat_rd),
        .stat_wr_i      (stat_wr),
        .wdata_i        (reg_wdata_i),
        .txdata_wr_i    (data_wr),
        .xfer_i         (xfer),
        .tx_done_i      (tx_done),
        .rx_ready_i     (rx_ready_i),
        .rx_mpb_i       (rx_mpb_i),
        .rx_overrun_i   (rx_overrun_i),
        .rx_frame_err_i (rx_frame_err_i),
        .rx_parity_err_i(rx_parity_err_i),
        .status_o       (status)
    );

    sst_tx #(.DATA_BITS(8)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .tx_enable_i(tx_enable_i),
        .bit_tick_i (bit_tick_i),
        .txdata_wr_i(data_wr),
        .wdata_i    (reg_wdata_i),
        .txe_i      (status[IDX_TXE]),
        .xfer_o     (xfer),
        .done_o     (tx_done),
        .busy_o     (tx_busy),
        .txd_o      (txd_o),
        .tdr_o      (tdr)
    );

    assign reg_rdata_o = (sel == SEL_TXDATA) ? tdr : status;

    // R11
    tend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[IDX_TEND] |-> !tx_busy);
    // R8
    data_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_enable_i && !standby_i) |=> !status[IDX_TXE]);
endmodule

// File: tb/test_serial_status_xmit.sv
module test_serial_status_xmit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 1'b0;
    logic       tx_enable_i = 1'b1;
    logic       bit_tick_i = 1'b0;
    logic       reg_sel_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       rx_ready_i = 1'b0;
    logic       rx_mpb_i = 1'b0;
    logic       rx_overrun_i = 1'b0;
    logic       rx_frame_err_i = 1'b0;
    logic       rx_parity_err_i = 1'b0;
    logic       txd_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_status_xmit i_serial_status_xmit (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek_status(string req, logic [7:0] exp);
        reg_sel_i = 1'b0;
        #1;
        check(req, reg_rdata_o, exp);
    endtask

    task automatic cpu_write(logic sel, logic [7:0] data);
        reg_sel_i = sel; reg_wdata_i = data; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic cpu_read;
        reg_sel_i = 1'b0; reg_rd_i = 1'b1;
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic rx_pulse(logic rdy, logic mpb, logic ovr, logic frm, logic par);
        rx_ready_i = rdy; rx_mpb_i = mpb; rx_overrun_i = ovr;
        rx_frame_err_i = frm; rx_parity_err_i = par;
        @(negedge clk);
        rx_ready_i = 0; rx_overrun_i = 0; rx_frame_err_i = 0; rx_parity_err_i = 0;
    endtask

    // called right after the transfer edge; checks each bit then ticks
    task automatic run_frame(logic [7:0] data);
        logic [9:0] frame;
        frame = {1'b1, data, 1'b0};
        for (int b = 0; b < 10; b++) begin
            check("R10 frame bit", {7'd0, txd_o}, {7'd0, frame[b]});
            bit_tick_i = 1'b1;
            @(negedge clk);
            bit_tick_i = 1'b0;
        end
    endtask

    task automatic t_reset_and_sw_write;
        peek_status("R1 reset value", 8'h84);
        check("R10 idle line", {7'd0, txd_o}, 8'h01);
        cpu_write(1'b0, 8'hFE);
        peek_status("R3 write ones no set", 8'h84);
        cpu_write(1'b0, 8'h01);
        peek_status("R6 bit0 set, R4 unarmed bit7 holds", 8'h85);
        cpu_write(1'b0, 8'h00);
        peek_status("R6 bit0 clear", 8'h84);
    endtask

    task automatic t_rx_events;
        rx_pulse(1, 1, 0, 0, 0);
        peek_status("R2 R7 receive-full and mp bit", 8'hC6);
        rx_pulse(0, 0, 1, 0, 0);
        peek_status("R2 overrun", 8'hE6);
        rx_pulse(0, 0, 0, 1, 0);
        peek_status("R2 framing", 8'hF6);
        rx_pulse(0, 0, 0, 0, 1);
        peek_status("R2 parity", 8'hFE);
    endtask

    task automatic t_clear_protocol;
        cpu_write(1'b0, 8'h00);
        peek_status("R4 write0 without read ignored", 8'hFE);
        cpu_read();
        cpu_write(1'b0, 8'hDE);
        peek_status("R4 armed overrun clears", 8'hDE);
        cpu_write(1'b0, 8'hEE);
        peek_status("R4 armed framing clears", 8'hCE);
        rx_pulse(0, 0, 1, 0, 0);
        cpu_write(1'b0, 8'hDE);
        peek_status("R4 re-set flag needs new read", 8'hEE);
    endtask

    task automatic t_set_wins;
        cpu_read();
        reg_sel_i = 1'b0; reg_wdata_i = 8'hBE; reg_wr_i = 1'b1;
        rx_ready_i = 1'b1; rx_mpb_i = 1'b0;
        @(negedge clk);
        reg_wr_i = 1'b0; rx_ready_i = 1'b0;
        peek_status("R5 set beats clear, R7 mp bit 0", 8'hEC);
        cpu_read();
        cpu_write(1'b0, 8'h86);
        peek_status("R4 clear all rx flags", 8'h84);
    endtask

    task automatic t_transmit;
        cpu_write(1'b1, 8'hA5);
        peek_status("R8 data write clears bit7", 8'h04);
        reg_sel_i = 1'b1; #1;
        check("R8 holding register readback", reg_rdata_o, 8'hA5);
        @(negedge clk);
        peek_status("R9 R11 transfer sets bit7 clears bit2", 8'h80);
        run_frame(8'hA5);
        peek_status("R11 done sets bit2", 8'h84);
        check("R10 idle after stop", {7'd0, txd_o}, 8'h01);
    endtask

    task automatic t_back_to_back;
        cpu_write(1'b1, 8'h3C);
        @(negedge clk);
        cpu_write(1'b1, 8'h81);
        peek_status("R8 pending while busy", 8'h00);
        run_frame(8'h3C);
        peek_status("R11 bit2 stays 0 with pending byte", 8'h00);
        @(negedge clk);
        peek_status("R11 next transfer one cycle later", 8'h80);
        run_frame(8'h81);
        peek_status("R11 done after second frame", 8'h84);
    endtask

    task automatic t_disabled;
        tx_enable_i = 1'b0;
        @(negedge clk);
        cpu_write(1'b1, 8'h55);
        peek_status("R9 forced empty beats data write", 8'h84);
        cpu_read();
        cpu_write(1'b0, 8'h04);
        peek_status("R9 forced empty beats sw clear", 8'h84);
        repeat (3) @(negedge clk);
        check("R9 no transfer when disabled", {7'd0, txd_o}, 8'h01);
        tx_enable_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 no stale send on enable", {7'd0, txd_o}, 8'h01);
    endtask

    task automatic t_standby;
        rx_pulse(0, 0, 1, 0, 0);
        cpu_write(1'b0, 8'h01);
        peek_status("R2 overrun before standby", 8'hA5);
        standby_i = 1'b1;
        @(negedge clk);
        standby_i = 1'b0;
        peek_status("R1 standby reload", 8'h84);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_sw_write();
        t_rx_events();
        t_clear_protocol();
        t_set_wins();
        t_transmit();
        t_back_to_back();
        t_disabled();
        t_standby();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule